// File: doc/BRIEF.md
# Reset Configuration Strap Capture

This block reads board-level configuration straps from pins that are shared with other functions. It does the reading at the moment the real-time-clock reset is released. It runs on the slow RTC clock. The raw active-low RTC reset passes through a synchronizer before a single release edge is detected. The straps are taken in two steps. The clock-select code and the upper memory-mode strap are taken on the release edge. The bus-width strap, the lower memory-mode strap and the instruction-extension enable are taken one RTC cycle later.

After both steps complete, the block publishes all the settings together as one configuration. It sets a valid flag and hands the shared output-capable pins to their normal role by raising their output enables. The published configuration includes the raw fields, a decoded memory map (boot-bank ROM kind, other-bank ROM kind, RAM kind) and a flag for the forbidden clock code. Downstream clock and memory controllers read these outputs. When the RTC reset is asserted again, the pins are released to high impedance and the last configuration is held, so a later release can capture fresh straps.

Top module: `cfg_strap_capture`

## Requirements
- R1: With rtc_rst_n driven high from before a rising clk_rtc edge, cfg_valid stays low through the third rising edge at which rtc_rst_n is high. It is high after the fourth such edge.
- R2: pin_clk_sel and pin_mode_hi are sampled at the third rising edge after release. Changes made to them after that edge do not appear in the published configuration.
- R3: pin_bus_width, pin_mode_lo and pin_ext16 are sampled one cycle later, at the fourth edge. Values present only before that edge are not published.
- R4: cfg_bus32 equals the sampled pin_bus_width (1 means a 32-bit bus, 0 a 16-bit bus). cfg_ext16 equals the sampled pin_ext16 (1 enables the 16-bit instruction mode).
- R5: cfg_mem_mode = {pin_mode_hi, pin_mode_lo}, decoded as follows:
  - 00: asynchronous ROM on all banks, EDO DRAM. All three decode outputs are 0.
  - 01: asynchronous boot ROM, synchronous ROM on the other banks, SDRAM. boot=0, bank=1, sdram=1.
  - 10: asynchronous ROM on all banks, SDRAM. boot=0, bank=0, sdram=1.
  - 11: synchronous ROM on all banks, SDRAM. boot=1, bank=1, sdram=1.
- R6: cfg_clk_err is 1 exactly when the published clock-select code is all ones (3'b111 by default). It is 0 for any other code.
- R7: Once rtc_rst_n has been sampled low at some edge, cfg_valid is low after the third edge that follows. While no new configuration is published, every configuration output holds its value whatever the strap pins do.
- R8: oe_serial, oe_bus_width and oe_mode_lo are all 1 while cfg_valid is 1, and all 0 otherwise, so the strap pins stay tri-stated during reset.
- R9: A release that lasts only one clk_rtc edge before rtc_rst_n falls again publishes nothing. cfg_valid stays low and the configuration keeps its previous value.
- R10: A synchronous high rst clears the block. Afterwards cfg_clk_sel=0, cfg_mem_mode=00, cfg_bus32=0, cfg_ext16=0, cfg_clk_err=0, cfg_valid=0, all decode outputs are 0, and all output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rtc | input | 1 | Slow real-time clock |
| rst | input | 1 | Synchronous active-high block reset |
| rtc_rst_n | input | 1 | Raw active-low RTC reset, asynchronous to clk_rtc |
| pin_clk_sel | input | CLK_SEL_W | Clock-select strap levels |
| pin_mode_hi | input | 1 | Upper memory-mode strap |
| pin_bus_width | input | 1 | Data-bus-width strap |
| pin_mode_lo | input | 1 | Lower memory-mode strap |
| pin_ext16 | input | 1 | Instruction-extension enable strap |
| cfg_clk_sel | output | CLK_SEL_W | Published clock-select code |
| cfg_mem_mode | output | 2 | Published memory-mode code {hi, lo} |
| cfg_bus32 | output | 1 | 1 = 32-bit data bus |
| cfg_ext16 | output | 1 | 1 = 16-bit instruction mode enabled |
| cfg_boot_rom_sync | output | 1 | Boot-bank ROM is synchronous |
| cfg_bank_rom_sync | output | 1 | Non-boot ROM banks are synchronous |
| cfg_ram_sdram | output | 1 | 1 = SDRAM, 0 = EDO DRAM |
| cfg_clk_err | output | 1 | Forbidden clock code was captured |
| cfg_valid | output | 1 | Configuration is published and current |
| oe_serial | output | CLK_SEL_W | Output enables of the clock-strap pins (serial outputs) |
| oe_bus_width | output | 1 | Output enable of the bus-width pin |
| oe_mode_lo | output | 1 | Output enable of the lower memory-mode pin |

## Verification
The bench builds the block with its defaults, CLK_SEL_W=3 and SYNC_STAGES=2. The 3-bit width makes the forbidden all-ones code one of only eight values, so it can be hit directly. The two-stage synchronizer fixes release-to-publish at four edges, so the bench can move the early pins just after the third edge and the late pins just before the fourth to show which edge each group is sampled on. With two stages, a one-edge release pulse is also enough to enter the pending state and then abandon it, which exercises the no-partial-publish path.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

    // Capture sequencer states
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,   // waiting for a release edge
        CAP_EARLY = 2'd1,   // early straps staged, late sample pending
        CAP_DONE  = 2'd2    // configuration published
    } cap_state_e;

    // Decoded memory map
    typedef struct packed {
        logic boot_rom_sync;
        logic bank_rom_sync;
        logic ram_sdram;
    } mem_map_t;

    // Straps taken one cycle after the release edge
    typedef struct packed {
        logic bus32;
        logic mode_lo;
        logic ext16;
    } late_straps_t;

    localparam int MODE_W = 2;

    function automatic mem_map_t decode_mode(input logic [MODE_W-1:0] code);
        mem_map_t m;
        unique case (code)
            2'b00:   m = '{boot_rom_sync: 1'b0, bank_rom_sync: 1'b0, ram_sdram: 1'b0};
            2'b01:   m = '{boot_rom_sync: 1'b0, bank_rom_sync: 1'b1, ram_sdram: 1'b1};
            2'b10:   m = '{boot_rom_sync: 1'b0, bank_rom_sync: 1'b0, ram_sdram: 1'b1};
            default: m = '{boot_rom_sync: 1'b1, bank_rom_sync: 1'b1, ram_sdram: 1'b1};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_n_raw,
    output logic rel_level,
    output logic rel_pulse
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain   <= '0;
            level_d <= 1'b0;
        end else begin
            chain[0] <= rst_n_raw;
            level_d  <= chain[LAST];
        end
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign rel_level = chain[LAST];
    assign rel_pulse = chain[LAST] & ~level_d;

endmodule

// File: rtl/strap_seq.sv
module strap_seq
    import strap_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rel_level,
    input  logic rel_pulse,
    output logic take_early,
    output logic publish,
    output logic valid
);
    cap_state_e state_q, state_d;

    always_comb begin
        state_d    = state_q;
        take_early = 1'b0;
        publish    = 1'b0;
        unique case (state_q)
            CAP_IDLE: begin
                if (rel_pulse) begin
                    take_early = 1'b1;
                    state_d    = CAP_EARLY;
                end
            end
            CAP_EARLY: begin
                if (rel_level) begin
                    publish = 1'b1;
                    state_d = CAP_DONE;
                end else begin
                    // reset came back before the late sample: abandon
                    state_d = CAP_IDLE;
                end
            end
            CAP_DONE: begin
                if (!rel_level) state_d = CAP_IDLE;
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CAP_IDLE;
        else     state_q <= state_d;
    end

    assign valid = (state_q == CAP_DONE);

endmodule

// File: rtl/strap_store.sv
module strap_store
    import strap_cfg_pkg::*;
#(
    parameter int CLK_SEL_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take_early,
    input  logic                 publish,
    input  logic [CLK_SEL_W-1:0] early_clk_sel,
    input  logic                 early_mode_hi,
    input  late_straps_t         late_in,
    output logic [CLK_SEL_W-1:0] pub_clk_sel,
    output logic [MODE_W-1:0]    pub_mode,
    output late_straps_t         pub_late,
    output mem_map_t             pub_map,
    output logic                 pub_clk_err
);
    localparam logic [CLK_SEL_W-1:0] FORBIDDEN_CODE = {CLK_SEL_W{1'b1}};

    logic [CLK_SEL_W-1:0] stage_clk_sel;
    logic                 stage_mode_hi;
    logic [MODE_W-1:0]    next_mode;

    assign next_mode = {stage_mode_hi, late_in.mode_lo};

    // staging register: early straps, not yet visible
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_clk_sel <= '0;
            stage_mode_hi <= 1'b0;
        end else if (take_early) begin
            stage_clk_sel <= early_clk_sel;
            stage_mode_hi <= early_mode_hi;
        end
    end

    // published configuration: every field updates in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pub_clk_sel <= '0;
            pub_mode    <= '0;
            pub_late    <= '0;
            pub_map     <= '0;
            pub_clk_err <= 1'b0;
        end else if (publish) begin
            pub_clk_sel <= stage_clk_sel;
            pub_mode    <= next_mode;
            pub_late    <= late_in;
            pub_map     <= decode_mode(next_mode);
            pub_clk_err <= (stage_clk_sel == FORBIDDEN_CODE);
        end
    end

endmodule

// File: rtl/strap_pin_ctrl.sv
module strap_pin_ctrl #(
    parameter int CLK_SEL_W = 3
) (
    input  logic                 valid,
    output logic [CLK_SEL_W-1:0] oe_serial,
    output logic                 oe_bus_width,
    output logic                 oe_mode_lo
);
    genvar g;
    generate
        for (g = 0; g < CLK_SEL_W; g++) begin : g_oe
            assign oe_serial[g] = valid;
        end
    endgenerate

    assign oe_bus_width = valid;
    assign oe_mode_lo   = valid;

endmodule

// File: rtl/cfg_strap_capture.sv
module cfg_strap_capture
    import strap_cfg_pkg::*;
#(
    parameter int CLK_SEL_W   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_rtc,
    input  logic                 rst,
    input  logic                 rtc_rst_n,
    input  logic [CLK_SEL_W-1:0] pin_clk_sel,
    input  logic                 pin_mode_hi,
    input  logic                 pin_bus_width,
    input  logic                 pin_mode_lo,
    input  logic                 pin_ext16,
    output logic [CLK_SEL_W-1:0] cfg_clk_sel,
    output logic [1:0]           cfg_mem_mode,
    output logic                 cfg_bus32,
    output logic                 cfg_ext16,
    output logic                 cfg_boot_rom_sync,
    output logic                 cfg_bank_rom_sync,
    output logic                 cfg_ram_sdram,
    output logic                 cfg_clk_err,
    output logic                 cfg_valid,
    output logic [CLK_SEL_W-1:0] oe_serial,
    output logic                 oe_bus_width,
    output logic                 oe_mode_lo
);
    logic         rel_level, rel_pulse;
    logic         take_early, publish, valid;
    late_straps_t late_in, pub_late;
    mem_map_t     pub_map;

    assign late_in = '{bus32: pin_bus_width, mode_lo: pin_mode_lo, ext16: pin_ext16};

    strap_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk_rtc),
        .rst       (rst),
        .rst_n_raw (rtc_rst_n),
        .rel_level (rel_level),
        .rel_pulse (rel_pulse)
    );

    strap_seq i_seq (
        .clk        (clk_rtc),
        .rst        (rst),
        .rel_level  (rel_level),
        .rel_pulse  (rel_pulse),
        .take_early (take_early),
        .publish    (publish),
        .valid      (valid)
    );

    strap_store #(.CLK_SEL_W(CLK_SEL_W)) i_store (
        .clk           (clk_rtc),
        .rst           (rst),
        .take_early    (take_early),
        .publish       (publish),
        .early_clk_sel (pin_clk_sel),
        .early_mode_hi (pin_mode_hi),
        .late_in       (late_in),
        .pub_clk_sel   (cfg_clk_sel),
        .pub_mode      (cfg_mem_mode),
        .pub_late      (pub_late),
        .pub_map       (pub_map),
        .pub_clk_err   (cfg_clk_err)
    );

    strap_pin_ctrl #(.CLK_SEL_W(CLK_SEL_W)) i_pins (
        .valid        (valid),
        .oe_serial    (oe_serial),
        .oe_bus_width (oe_bus_width),
        .oe_mode_lo   (oe_mode_lo)
    );

    assign cfg_bus32         = pub_late.bus32;
    assign cfg_ext16         = pub_late.ext16;
    assign cfg_boot_rom_sync = pub_map.boot_rom_sync;
    assign cfg_bank_rom_sync = pub_map.bank_rom_sync;
    assign cfg_ram_sdram     = pub_map.ram_sdram;
    assign cfg_valid         = valid;

endmodule

// File: rtl/strap_cfg_checks.sv
module strap_cfg_checks #(
    parameter int CLK_SEL_W = 3
) (
    input logic                 clk_rtc,
    input logic                 rst,
    input logic                 rtc_rst_n,
    input logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input logic [1:0]           cfg_mem_mode,
    input logic                 cfg_bus32,
    input logic                 cfg_ext16,
    input logic                 cfg_boot_rom_sync,
    input logic                 cfg_bank_rom_sync,
    input logic                 cfg_ram_sdram,
    input logic                 cfg_clk_err,
    input logic                 cfg_valid,
    input logic [CLK_SEL_W-1:0] oe_serial,
    input logic                 oe_bus_width,
    input logic                 oe_mode_lo
);
    logic [CLK_SEL_W+8:0] cfg_vec;
    assign cfg_vec = {cfg_clk_sel, cfg_mem_mode, cfg_bus32, cfg_ext16, cfg_boot_rom_sync,
                      cfg_bank_rom_sync, cfg_ram_sdram, cfg_clk_err, 1'b0};

    AST_OE_NEEDS_VALID: assert property (@(posedge clk_rtc) disable iff (rst)
        (|oe_serial || oe_bus_width || oe_mode_lo) |-> cfg_valid); // R8
    AST_OE_ALL_WHEN_VALID: assert property (@(posedge clk_rtc) disable iff (rst)
        cfg_valid |-> (&oe_serial && oe_bus_width && oe_mode_lo)); // R8
    AST_RISE_AFTER_RELEASE: assert property (@(posedge clk_rtc) disable iff (rst)
        $rose(cfg_valid) |-> ($past(rtc_rst_n, 3) && $past(rtc_rst_n, 4))); // R1
    AST_HOLD_UNLESS_PUBLISH: assert property (@(posedge clk_rtc) disable iff (rst)
        !$rose(cfg_valid) |-> $stable(cfg_vec)); // R7
    AST_DROP_ON_RESET: assert property (@(posedge clk_rtc) disable iff (rst)
        !$past(rtc_rst_n, 3) |-> !cfg_valid); // R7
    AST_FORBIDDEN_CODE: assert property (@(posedge clk_rtc) disable iff (rst)
        $rose(cfg_valid) |-> (cfg_clk_err == (&cfg_clk_sel))); // R6
    AST_BOOT_SYNC_ORDER: assert property (@(posedge clk_rtc) disable iff (rst)
        cfg_boot_rom_sync |-> (cfg_bank_rom_sync && cfg_ram_sdram)); // R5
    AST_EDO_ALL_ASYNC: assert property (@(posedge clk_rtc) disable iff (rst)
        !cfg_ram_sdram |-> (!cfg_bank_rom_sync && !cfg_boot_rom_sync)); // R5

endmodule

bind cfg_strap_capture strap_cfg_checks #(.CLK_SEL_W(CLK_SEL_W)) i_checks (
    .clk_rtc           (clk_rtc),
    .rst               (rst),
    .rtc_rst_n         (rtc_rst_n),
    .cfg_clk_sel       (cfg_clk_sel),
    .cfg_mem_mode      (cfg_mem_mode),
    .cfg_bus32         (cfg_bus32),
    .cfg_ext16         (cfg_ext16),
    .cfg_boot_rom_sync (cfg_boot_rom_sync),
    .cfg_bank_rom_sync (cfg_bank_rom_sync),
    .cfg_ram_sdram     (cfg_ram_sdram),
    .cfg_clk_err       (cfg_clk_err),
    .cfg_valid         (cfg_valid),
    .oe_serial         (oe_serial),
    .oe_bus_width      (oe_bus_width),
    .oe_mode_lo        (oe_mode_lo)
);

// File: tb/test_cfg_strap_capture.sv
module test_cfg_strap_capture;
    localparam int CLK_PERIOD = 10;
    localparam int W = 3;

    typedef struct packed {
        logic [W-1:0] cs;
        logic [1:0]   mode;
        logic         bus;
        logic         ext;
        logic         err;
        logic         boot;
        logic         bank;
        logic         sdram;
    } exp_t;

    logic         clk_rtc = 1'b0;
    logic         rst = 1'b1;
    logic         rtc_rst_n = 1'b0;
    logic [W-1:0] pin_clk_sel = '0;
    logic         pin_mode_hi = 1'b0, pin_bus_width = 1'b0, pin_mode_lo = 1'b0, pin_ext16 = 1'b0;
    logic [W-1:0] cfg_clk_sel;
    logic [1:0]   cfg_mem_mode;
    logic         cfg_bus32, cfg_ext16, cfg_boot_rom_sync, cfg_bank_rom_sync, cfg_ram_sdram;
    logic         cfg_clk_err, cfg_valid;
    logic [W-1:0] oe_serial;
    logic         oe_bus_width, oe_mode_lo;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    logic prev_valid = 1'b0;
    exp_t exp_q[$];
    exp_t last_exp;

    always #(CLK_PERIOD/2) clk_rtc = ~clk_rtc;

    cfg_strap_capture i_cfg_strap_capture (
        .clk_rtc(clk_rtc), .rst(rst), .rtc_rst_n(rtc_rst_n),
        .pin_clk_sel(pin_clk_sel), .pin_mode_hi(pin_mode_hi), .pin_bus_width(pin_bus_width),
        .pin_mode_lo(pin_mode_lo), .pin_ext16(pin_ext16),
        .cfg_clk_sel(cfg_clk_sel), .cfg_mem_mode(cfg_mem_mode), .cfg_bus32(cfg_bus32),
        .cfg_ext16(cfg_ext16), .cfg_boot_rom_sync(cfg_boot_rom_sync),
        .cfg_bank_rom_sync(cfg_bank_rom_sync), .cfg_ram_sdram(cfg_ram_sdram),
        .cfg_clk_err(cfg_clk_err), .cfg_valid(cfg_valid), .oe_serial(oe_serial),
        .oe_bus_width(oe_bus_width), .oe_mode_lo(oe_mode_lo)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // expected values from the requirements
    function automatic exp_t mk_exp(input logic [W-1:0] cs, input logic hi, input logic bw,
                                    input logic lo, input logic ex);
        exp_t e;
        e.cs   = cs;
        e.mode = {hi, lo};
        e.bus  = bw;
        e.ext  = ex;
        e.err  = (cs == 3'b111);
        case ({hi, lo})
            2'b00:   {e.boot, e.bank, e.sdram} = 3'b000;
            2'b01:   {e.boot, e.bank, e.sdram} = 3'b011;
            2'b10:   {e.boot, e.bank, e.sdram} = 3'b001;
            default: {e.boot, e.bank, e.sdram} = 3'b111;
        endcase
        return e;
    endfunction

    task automatic cmp_cfg(input exp_t e, input string ctx);
        chk(cfg_clk_sel == e.cs, {"R2 clk_sel ", ctx}, cfg_clk_sel, e.cs);
        chk(cfg_mem_mode == e.mode, {"R3 mem_mode ", ctx}, cfg_mem_mode, e.mode);
        chk(cfg_bus32 == e.bus, {"R4 bus32 ", ctx}, cfg_bus32, e.bus);
        chk(cfg_ext16 == e.ext, {"R4 ext16 ", ctx}, cfg_ext16, e.ext);
        chk(cfg_clk_err == e.err, {"R6 clk_err ", ctx}, cfg_clk_err, e.err);
        chk({cfg_boot_rom_sync, cfg_bank_rom_sync, cfg_ram_sdram} == {e.boot, e.bank, e.sdram},
            {"R5 decode ", ctx}, {cfg_boot_rom_sync, cfg_bank_rom_sync, cfg_ram_sdram},
            {e.boot, e.bank, e.sdram});
    endtask

    // monitor: compares on each publication, checks enables every cycle
    always @(negedge clk_rtc) begin
        if (mon_on) begin
            if (cfg_valid && !prev_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected publication", 1, 0);
                end else begin
                    last_exp = exp_q.pop_front();
                    cmp_cfg(last_exp, "on publish");
                end
            end
            chk({oe_serial, oe_bus_width, oe_mode_lo} == {(W+2){cfg_valid}}, "R8 output enables",
                {oe_serial, oe_bus_width, oe_mode_lo}, {(W+2){cfg_valid}});
            prev_valid = cfg_valid;
        end
    end

    // driver: full release with early/late pins moved around their sampling edges
    task automatic release_cfg(input logic [W-1:0] cs, input logic hi, input logic bw,
                               input logic lo, input logic ex);
        exp_q.push_back(mk_exp(cs, hi, bw, lo, ex));
        @(negedge clk_rtc);
        rtc_rst_n = 1'b1;
        pin_clk_sel = cs; pin_mode_hi = hi;
        pin_bus_width = ~bw; pin_mode_lo = ~lo; pin_ext16 = ~ex;
        @(negedge clk_rtc); @(negedge clk_rtc);
        chk(cfg_valid == 1'b0, "R1 valid low after 2nd edge", cfg_valid, 0);
        @(negedge clk_rtc);
        chk(cfg_valid == 1'b0, "R1 valid low after 3rd edge", cfg_valid, 0);
        pin_clk_sel = ~cs; pin_mode_hi = ~hi;
        pin_bus_width = bw; pin_mode_lo = lo; pin_ext16 = ex;
        @(negedge clk_rtc);
        chk(cfg_valid == 1'b1, "R1 valid high after 4th edge", cfg_valid, 1);
        pin_clk_sel = cs ^ 3'b101; pin_bus_width = ~bw; pin_mode_lo = ~lo; pin_ext16 = ~ex;
        repeat (3) @(negedge clk_rtc);
        cmp_cfg(last_exp, "R7 pins toggled after publish");
    endtask

    task automatic assert_rtc_reset();
        @(negedge clk_rtc);
        rtc_rst_n = 1'b0;
        pin_clk_sel = ~pin_clk_sel; pin_mode_hi = ~pin_mode_hi; pin_mode_lo = ~pin_mode_lo;
        repeat (3) @(negedge clk_rtc);
        chk(cfg_valid == 1'b0, "R7 valid low three edges into reset", cfg_valid, 0);
        cmp_cfg(last_exp, "R7 held during reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_rtc);
        rst = 1'b0;
        @(negedge clk_rtc);
        last_exp = '0;
        cmp_cfg(last_exp, "R10 after rst");
        chk(cfg_valid == 1'b0, "R10 valid after rst", cfg_valid, 0);
        chk({oe_serial, oe_bus_width, oe_mode_lo} == '0, "R10 enables after rst",
            {oe_serial, oe_bus_width, oe_mode_lo}, 0);
        mon_on = 1'b1;

        release_cfg(3'b010, 1'b0, 1'b1, 1'b1, 1'b1);   // mode 01, 32-bit, ext on
        assert_rtc_reset();
        release_cfg(3'b111, 1'b0, 1'b0, 1'b0, 1'b0);   // forbidden code, mode 00
        assert_rtc_reset();
        release_cfg(3'b101, 1'b1, 1'b1, 1'b0, 1'b0);   // mode 10
        assert_rtc_reset();

        // R9: one-edge release, then reset again
        @(negedge clk_rtc);
        rtc_rst_n = 1'b1;
        pin_clk_sel = 3'b000; pin_mode_hi = 1'b1; pin_bus_width = 1'b0;
        pin_mode_lo = 1'b1; pin_ext16 = 1'b1;
        @(negedge clk_rtc);
        rtc_rst_n = 1'b0;
        repeat (8) @(negedge clk_rtc);
        chk(cfg_valid == 1'b0, "R9 valid after short release", cfg_valid, 0);
        cmp_cfg(last_exp, "R9 config after short release");

        release_cfg(3'b001, 1'b1, 1'b0, 1'b1, 1'b1);   // mode 11

        // R10: block reset while published
        @(negedge clk_rtc);
        rst = 1'b1;
        repeat (3) @(negedge clk_rtc);
        rst = 1'b0;
        mon_on = 1'b0;
        @(negedge clk_rtc);
        cmp_cfg('0, "R10 rst while valid");
        chk(cfg_valid == 1'b0, "R10 valid cleared", cfg_valid, 0);
        chk(exp_q.size() == 0, "R1 all publications seen", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule